// File: doc/BRIEF.md
# Lockable Boot ROM and Mailbox RAM

This peripheral puts two memories into one byte-addressed CPU window. The low part of the window is a read-only boot ROM. Its contents come from a fixed formula, so no file has to be loaded. The rest of the window is a small shared RAM that a second agent, the peripheral engine, can also read and write through a port of its own. The CPU reads the ROM while the machine boots. When boot is finished, the CPU pulses a lock request. From then on, ROM reads return zero and record a sticky violation. Only the reset sequencer's unlock strobe, or a full reset, opens the ROM again.

The RAM is always reachable and acts as a mailbox. Its final byte is a doorbell. A CPU write to that byte raises a pending flag toward the peripheral engine. The engine writes its answers into the RAM and then pulses done, which drops the flag. By convention, a boot-time seed is kept at RAM byte 0x24.

Top module: `boot_window_mbox`

## Requirements
- R1: CPU window offsets 0 to 1983 select the ROM. Offsets 1984 to 2047 select the RAM, with RAM byte k at window offset 1984+k, which is the same byte the peripheral port reaches at address k.
- R2: A CPU read (cpuRd high at an edge) presents its byte on cpuRdata with cpuRvalid high in the following cycle. With no read, cpuRvalid is low.
- R3: While unlocked, the ROM byte at window offset a equals a[7:0] XOR {a[10:8], 5'b10101}.
- R4: A cpuLockReq pulse locks the ROM. While locked, ROM reads return 0x00, and no CPU read or write clears the lock.
- R5: The lock clears only on an nmiUnlock pulse or on reset. When cpuLockReq and nmiUnlock arrive in the same cycle, the ROM ends up unlocked.
- R6: A ROM read while locked sets accessViolation. The flag stays set, including across nmiUnlock, until reset.
- R7: CPU writes to ROM offsets change neither the ROM data read back nor any RAM byte.
- R8: Both the CPU and the peripheral port can write and read every RAM byte. perRdata shows the addressed byte combinationally.
- R9: When the CPU and the peripheral port write the same RAM byte in the same cycle, the CPU data is stored.
- R10: A CPU write to window offset 2047 (RAM byte 63) sets cmdPending, and a perDone pulse clears it. If both happen in one cycle, the flag is set. Writes to other RAM bytes leave the flag unchanged.
- R11: After reset: cpuRdata is 0, cpuRvalid is 0, the ROM is unlocked, cmdPending and accessViolation are 0, and every RAM byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuRd | input | 1 | CPU read strobe |
| cpuWr | input | 1 | CPU write strobe |
| cpuAddr | input | 11 | CPU byte offset in the window |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | CPU read data (registered) |
| cpuRvalid | output | 1 | Read data valid |
| cpuLockReq | input | 1 | Boot-done pulse that locks the ROM |
| nmiUnlock | input | 1 | Reset-sequencer pulse that unlocks the ROM |
| perAddr | input | 6 | Peripheral RAM byte address |
| perWr | input | 1 | Peripheral write strobe |
| perWdata | input | 8 | Peripheral write data |
| perRdata | output | 8 | Peripheral read data (combinational) |
| perDone | input | 1 | Peripheral has posted results; clears pending |
| cmdPending | output | 1 | Doorbell raised by CPU |
| romLocked | output | 1 | ROM lock state |
| accessViolation | output | 1 | Sticky locked-ROM read flag |

## Verification
The bench reads the ROM's first byte, its last byte and a byte that exercises the upper address bits, then reads the first RAM byte across the boundary. A faulty decode would return ROM data in the RAM range or the reverse. It drives a lock request together with an unlock in the same cycle, and a doorbell write together with done in the same cycle. Getting either priority wrong would leave the ROM shut or drop a fresh command. A same-byte write collision between the two RAM ports must keep the CPU data, and a ROM-range write must leave the aliased RAM byte untouched. After an unlock, the violation flag must still be set, which catches a design that clears it on the unlock strobe.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef struct packed {
    logic romRd;
    logic ramRd;
    logic zeroRd;
    logic ramWr;
  } mboxStrobe_t;

  function automatic logic [7:0] romByte(input logic [15:0] a);
    logic [15:0] sh;
    sh = a >> 8;
    return a[7:0] ^ {sh[2:0], 5'b10101};
  endfunction
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ROM_BYTES = 1984,
  parameter int RAM_BYTES = 64,
  parameter int ADDR_W = $clog2(ROM_BYTES + RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuLockReq,
  input  logic              nmiUnlock,
  input  logic              perDone,
  output mboxStrobe_t       strb,
  output logic              romLocked,
  output logic              accessViolation,
  output logic              cmdPending
);
  localparam logic [ADDR_W-1:0] RomEnd  = ADDR_W'(ROM_BYTES);
  localparam logic [ADDR_W-1:0] CmdAddr = ADDR_W'(ROM_BYTES + RAM_BYTES - 1);

  logic inRom;
  logic cmdHit;

  always_comb begin
    inRom       = cpuAddr < RomEnd;
    strb.romRd  = cpuRd & inRom & ~romLocked;
    strb.zeroRd = cpuRd & inRom & romLocked;
    strb.ramRd  = cpuRd & ~inRom;
    strb.ramWr  = cpuWr & ~inRom;
    cmdHit      = strb.ramWr & (cpuAddr == CmdAddr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romLocked       <= 1'b0;
      accessViolation <= 1'b0;
      cmdPending      <= 1'b0;
    end else begin
      if (nmiUnlock)       romLocked <= 1'b0;
      else if (cpuLockReq) romLocked <= 1'b1;
      if (strb.zeroRd)     accessViolation <= 1'b1;
      if (cmdHit)          cmdPending <= 1'b1;
      else if (perDone)    cmdPending <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int ROM_BYTES = 1984,
  parameter int RAM_BYTES = 64,
  parameter int ADDR_W = $clog2(ROM_BYTES + RAM_BYTES),
  parameter int IDX_W = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWdata,
  input  mboxStrobe_t       strb,
  input  logic [IDX_W-1:0]  perAddr,
  input  logic              perWr,
  input  logic [7:0]        perWdata,
  output logic [7:0]        perRdata,
  output logic [7:0]        cpuRdata,
  output logic              cpuRvalid
);
  logic [7:0]        ramQ [RAM_BYTES];
  logic [ADDR_W-1:0] relAddr;
  logic [IDX_W-1:0]  cpuIdx;
  logic [7:0]        romQ;

  always_comb begin
    relAddr  = cpuAddr - ADDR_W'(ROM_BYTES);
    cpuIdx   = relAddr[IDX_W-1:0];
    romQ     = romByte(16'(cpuAddr));
    perRdata = ramQ[perAddr];
  end

  for (genvar i = 0; i < RAM_BYTES; i++) begin : gByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ramQ[i] <= 8'h00;
      else if (strb.ramWr && cpuIdx == IDX_W'(i)) ramQ[i] <= cpuWdata;
      else if (perWr && perAddr == IDX_W'(i))     ramQ[i] <= perWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuRdata  <= 8'h00;
      cpuRvalid <= 1'b0;
    end else begin
      cpuRvalid <= strb.romRd | strb.ramRd | strb.zeroRd;
      if (strb.romRd)       cpuRdata <= romQ;
      else if (strb.ramRd)  cpuRdata <= ramQ[cpuIdx];
      else if (strb.zeroRd) cpuRdata <= 8'h00;
    end
  end
endmodule

// File: rtl/boot_window_mbox.sv
module boot_window_mbox
  import mbox_pkg::*;
#(
  parameter int ROM_BYTES = 1984,
  parameter int RAM_BYTES = 64,
  parameter int ADDR_W = $clog2(ROM_BYTES + RAM_BYTES),
  parameter int IDX_W = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWdata,
  output logic [7:0]        cpuRdata,
  output logic              cpuRvalid,
  input  logic              cpuLockReq,
  input  logic              nmiUnlock,
  input  logic [IDX_W-1:0]  perAddr,
  input  logic              perWr,
  input  logic [7:0]        perWdata,
  output logic [7:0]        perRdata,
  input  logic              perDone,
  output logic              cmdPending,
  output logic              romLocked,
  output logic              accessViolation
);
  mboxStrobe_t strb;

  mbox_ctrl #(.ROM_BYTES(ROM_BYTES), .RAM_BYTES(RAM_BYTES), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuLockReq(cpuLockReq), .nmiUnlock(nmiUnlock), .perDone(perDone),
    .strb(strb), .romLocked(romLocked), .accessViolation(accessViolation),
    .cmdPending(cmdPending)
  );

  mbox_datapath #(.ROM_BYTES(ROM_BYTES), .RAM_BYTES(RAM_BYTES), .ADDR_W(ADDR_W),
                  .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .strb(strb),
    .perAddr(perAddr), .perWr(perWr), .perWdata(perWdata), .perRdata(perRdata),
    .cpuRdata(cpuRdata), .cpuRvalid(cpuRvalid)
  );
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int ROM_BYTES = 1984,
  parameter int RAM_BYTES = 64,
  parameter int ADDR_W = $clog2(ROM_BYTES + RAM_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuRd,
  input logic              cpuWr,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuLockReq,
  input logic              nmiUnlock,
  input logic              perDone,
  input logic [7:0]        cpuRdata,
  input logic              cpuRvalid,
  input logic              romLocked,
  input logic              accessViolation,
  input logic              cmdPending
);
  localparam logic [ADDR_W-1:0] RomEnd  = ADDR_W'(ROM_BYTES);
  localparam logic [ADDR_W-1:0] CmdAddr = ADDR_W'(ROM_BYTES + RAM_BYTES - 1);

  a_r2_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    cpuRd |=> cpuRvalid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !cpuRd |=> !cpuRvalid);
  a_r4_lock_sets: assert property (@(posedge clk) disable iff (!rstN)
    (cpuLockReq && !nmiUnlock) |=> romLocked);
  a_r4_locked_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && cpuAddr < RomEnd && romLocked) |=> (cpuRdata == 8'h00));
  a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rstN)
    (romLocked && !nmiUnlock) |=> romLocked);
  a_r5_unlock: assert property (@(posedge clk) disable iff (!rstN)
    nmiUnlock |=> !romLocked);
  a_r6_violation_sticky: assert property (@(posedge clk) disable iff (!rstN)
    accessViolation |=> accessViolation);
  a_r6_violation_sets: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && cpuAddr < RomEnd && romLocked) |=> accessViolation);
  a_r10_cmd_sets: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr == CmdAddr) |=> cmdPending);
  a_r10_cmd_clears: assert property (@(posedge clk) disable iff (!rstN)
    (perDone && !(cpuWr && cpuAddr == CmdAddr)) |=> !cmdPending);
endmodule

bind boot_window_mbox mbox_checker #(.ROM_BYTES(ROM_BYTES), .RAM_BYTES(RAM_BYTES),
                                     .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
  .cpuLockReq(cpuLockReq), .nmiUnlock(nmiUnlock), .perDone(perDone),
  .cpuRdata(cpuRdata), .cpuRvalid(cpuRvalid), .romLocked(romLocked),
  .accessViolation(accessViolation), .cmdPending(cmdPending)
);

// File: tb/sim_boot_window_mbox.sv
module sim_boot_window_mbox;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuRd = 1'b0, cpuWr = 1'b0;
  logic [10:0] cpuAddr = '0;
  logic [7:0]  cpuWdata = '0;
  logic [7:0]  cpuRdata;
  logic        cpuRvalid;
  logic        cpuLockReq = 1'b0, nmiUnlock = 1'b0;
  logic [5:0]  perAddr = '0;
  logic        perWr = 1'b0;
  logic [7:0]  perWdata = '0;
  logic [7:0]  perRdata;
  logic        perDone = 1'b0;
  logic        cmdPending, romLocked, accessViolation;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  boot_window_mbox u0 (
    .clk(clk), .rstN(rstN), .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuRvalid(cpuRvalid),
    .cpuLockReq(cpuLockReq), .nmiUnlock(nmiUnlock), .perAddr(perAddr),
    .perWr(perWr), .perWdata(perWdata), .perRdata(perRdata), .perDone(perDone),
    .cmdPending(cmdPending), .romLocked(romLocked), .accessViolation(accessViolation)
  );

  function automatic logic [7:0] expRom(input int a);
    return 8'(a & 8'hFF) ^ {3'((a >> 8) & 7), 5'b10101};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input int a, input logic [7:0] d);
    cpuWr = 1'b1; cpuAddr = 11'(a); cpuWdata = d;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic cpuRead(input int a, output logic [7:0] d, output logic v);
    cpuRd = 1'b1; cpuAddr = 11'(a);
    @(negedge clk);
    cpuRd = 1'b0;
    d = cpuRdata; v = cpuRvalid;
  endtask

  task automatic perWrite(input int a, input logic [7:0] d);
    perWr = 1'b1; perAddr = 6'(a); perWdata = d;
    @(negedge clk);
    perWr = 1'b0;
  endtask

  task automatic perPeek(input int a, output logic [7:0] d);
    perAddr = 6'(a);
    #1 d = perRdata;
  endtask

  task automatic tReset();
    logic [7:0] d;
    chk("R11 rdata", cpuRdata, 0);
    chk("R11 rvalid", cpuRvalid, 0);
    chk("R11 locked", romLocked, 0);
    chk("R11 pending", cmdPending, 0);
    chk("R11 violation", accessViolation, 0);
    perPeek(63, d); chk("R11 ram zero", d, 0);
  endtask

  task automatic tRom();
    logic [7:0] d; logic v;
    cpuRead(0, d, v);    chk("R3 rom[0]", d, expRom(0)); chk("R2 valid", v, 1);
    cpuRead(256, d, v);  chk("R3 rom[256]", d, expRom(256));
    cpuRead(1983, d, v); chk("R1 R3 rom last", d, expRom(1983));
    @(negedge clk);      chk("R2 idle valid low", cpuRvalid, 0);
    cpuRead(1984, d, v); chk("R1 ram boundary", d, 0);
  endtask

  task automatic tRam();
    logic [7:0] d; logic v;
    cpuWrite(1984 + 36, 8'hA5);
    perPeek(36, d);              chk("R1 R8 cpu->per seed byte", d, 8'hA5);
    perWrite(16, 8'h3C);
    cpuRead(1984 + 16, d, v);    chk("R8 per->cpu", d, 8'h3C);
  endtask

  task automatic tRomWrite();
    logic [7:0] d; logic v;
    cpuWrite(5, 8'hFF);
    cpuRead(5, d, v);  chk("R7 rom unchanged", d, expRom(5));
    perPeek(5, d);     chk("R7 ram untouched", d, 0);
  endtask

  task automatic tConflict();
    logic [7:0] d;
    cpuWr = 1'b1; cpuAddr = 11'(1984 + 7); cpuWdata = 8'h11;
    perWr = 1'b1; perAddr = 6'd7; perWdata = 8'h22;
    @(negedge clk);
    cpuWr = 1'b0; perWr = 1'b0;
    perPeek(7, d); chk("R9 cpu wins", d, 8'h11);
  endtask

  task automatic tCmd();
    cpuWrite(2046, 8'h01);       chk("R10 other byte no flag", cmdPending, 0);
    cpuWrite(2047, 8'h01);       chk("R10 doorbell set", cmdPending, 1);
    perDone = 1'b1; @(negedge clk); perDone = 1'b0;
    chk("R10 done clears", cmdPending, 0);
    cpuWr = 1'b1; cpuAddr = 11'd2047; cpuWdata = 8'h02; perDone = 1'b1;
    @(negedge clk);
    cpuWr = 1'b0; perDone = 1'b0;
    chk("R10 simultaneous set wins", cmdPending, 1);
    perDone = 1'b1; @(negedge clk); perDone = 1'b0;
  endtask

  task automatic tLock();
    logic [7:0] d; logic v;
    cpuLockReq = 1'b1; @(negedge clk); cpuLockReq = 1'b0;
    chk("R4 locked", romLocked, 1);
    chk("R6 no violation yet", accessViolation, 0);
    cpuRead(0, d, v);            chk("R4 locked read zero", d, 0);
    chk("R6 violation set", accessViolation, 1);
    cpuWrite(3, 8'h55);
    cpuRead(1984 + 36, d, v);    chk("R4 ram still open", d, 8'hA5);
    chk("R4 lock survives access", romLocked, 1);
    nmiUnlock = 1'b1; @(negedge clk); nmiUnlock = 1'b0;
    chk("R5 unlocked", romLocked, 0);
    cpuRead(0, d, v);            chk("R5 rom readable", d, expRom(0));
    chk("R6 sticky past unlock", accessViolation, 1);
    cpuLockReq = 1'b1; nmiUnlock = 1'b1; @(negedge clk);
    cpuLockReq = 1'b0; nmiUnlock = 1'b0;
    chk("R5 unlock beats lock", romLocked, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRom();
    tRam();
    tRomWrite();
    tConflict();
    tCmd();
    tLock();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule